// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in, with no clock, and produces a 16-bit sum, a carry-out and a signed-overflow flag. The operand width is split into four 4-bit groups. Inside a group, each bit's carry is formed in one flat sum-of-products level from the per-bit generate term (A AND B), the propagate term (A OR B) and the group's carry-in, so no carry passes from bit to bit inside a group. Between groups the carry still ripples: the carry-out of the top bit of one group is the carry-in of the next group, and the top group's carry-out is the block's carry-out.

The block is meant to sit in a datapath stage where one addition must settle within a cycle. Sum bit i is the XOR of both operand bits and the carry out of bit i-1; the external carry-in takes that place for bit 0. Overflow for two's-complement operands is flagged when the carry into the most significant bit differs from the carry out of it.

Top module: `grouped_cla_adder`

## Requirements
- R1: `sum` equals the low 16 bits of opA + opB + carryIn, treated as unsigned numbers.
- R2: `carryOut` equals bit 16 of the unsigned total opA + opB + carryIn.
- R3: `overflow` is 1 exactly when opA[15] equals opB[15] and sum[15] differs from them. For example, 0x7FFF + 0x0001 sets it, and 0xFFFF + 0x0001 does not.
- R4: With carryIn = 1, opA = 0xFFFF and opB = 0x0000, the carry passes through every group and gives sum = 0x0000 and carryOut = 1. Every internal carry matches the bit-serial recurrence C(k) = G(k) | P(k)·C(k-1).
- R5: A carry generated at a single bit i (opA = opB = 1 << i, carryIn = 0) makes sum = 1 << (i+1) for i < 15. For i = 15 it makes sum = 0 and carryOut = 1.
- R6: For every 4-bit value pair and every carryIn, placed in any one of the four group positions with the other bits zero, the sum and carry-out are correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum, modulo 2^16 |
| carryOut | output | 1 | Carry out of bit 15 |
| overflow | output | 1 | Two's-complement overflow flag |

## Verification
Each 4-bit slice is tested with every operand pair and both carry-in values. This exposes wrong terms in a group's flattened carry equations, and running it in each group position shows whether a group receives the wrong neighbour carry. Walking a single generate bit across all positions catches a group-to-group link that is missing or shifted. An all-propagate operand shows whether the carry-in reaches the top. Random full-width vectors, together with the signed corner cases around 0x7FFF and 0x8000, separate correct overflow logic from logic that only looks at the carry-out.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Per-bit terms formed once and shared by the group lookahead logic.
  typedef struct packed {
    logic gen;   // both operand bits set
    logic prop;  // at least one operand bit set
    logic half;  // operand bits differ
  } bitTerm_t;
endpackage

// File: rtl/cla_pg_stage.sv
module cla_pg_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]                   opA,
  input  logic [WIDTH-1:0]                   opB,
  output cla_pkg::bitTerm_t [WIDTH-1:0]      terms
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign terms[i].gen  = opA[i] & opB[i];
    assign terms[i].prop = opA[i] | opB[i];
    assign terms[i].half = opA[i] ^ opB[i];
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GROUP_W = 4
) (
  input  cla_pkg::bitTerm_t [GROUP_W-1:0] terms,
  input  logic                            groupCin,
  output logic [GROUP_W-1:0]              carryVec,
  output logic [GROUP_W-1:0]              sumBits
);
  // Flattened lookahead: every carry is one OR of AND terms.
  always_comb begin
    for (int k = 0; k < GROUP_W; k++) begin
      logic orTerm;
      logic andTerm;
      andTerm = groupCin;
      for (int i = 0; i <= k; i++) andTerm = andTerm & terms[i].prop;
      orTerm = andTerm;
      for (int j = 0; j <= k; j++) begin
        andTerm = terms[j].gen;
        for (int i = j + 1; i <= k; i++) andTerm = andTerm & terms[i].prop;
        orTerm = orTerm | andTerm;
      end
      carryVec[k] = orTerm;
    end
  end

  for (genvar i = 0; i < GROUP_W; i++) begin : g_sum
    if (i == 0) begin : g_first
      assign sumBits[i] = terms[i].half ^ groupCin;
    end else begin : g_rest
      assign sumBits[i] = terms[i].half ^ carryVec[i-1];
    end
  end

  // R4: the flattened carries must agree with the bit-serial recurrence.
  always_comb begin
    logic rip;
    rip = groupCin;
    for (int k = 0; k < GROUP_W; k++) begin
      rip = terms[k].gen | (terms[k].prop & rip);
      a_r4_carry_matches_ripple: assert (carryVec[k] == rip)
        else $error("R4 lookahead carry %0d differs from ripple", k);
    end
  end

  // R6: the group result equals xor + 2*and + carry-in of its own slice.
  always_comb begin
    logic [GROUP_W-1:0] xorPart;
    logic [GROUP_W-1:0] andPart;
    for (int i = 0; i < GROUP_W; i++) begin
      xorPart[i] = terms[i].half;
      andPart[i] = terms[i].gen;
    end
    a_r6_group_total: assert ({carryVec[GROUP_W-1], sumBits} ==
        ({1'b0, xorPart} + {andPart, 1'b0} + {{GROUP_W{1'b0}}, groupCin}))
      else $error("R6 group total mismatch");
  end
endmodule

// File: rtl/grouped_cla_adder.sv
module grouped_cla_adder #(
  parameter int GROUP_W     = 4,
  parameter int GROUP_COUNT = 4
) (
  input  logic [GROUP_W*GROUP_COUNT-1:0] opA,
  input  logic [GROUP_W*GROUP_COUNT-1:0] opB,
  input  logic                           carryIn,
  output logic [GROUP_W*GROUP_COUNT-1:0] sum,
  output logic                           carryOut,
  output logic                           overflow
);
  localparam int WIDTH = GROUP_W * GROUP_COUNT;

  cla_pkg::bitTerm_t [WIDTH-1:0] terms;
  logic [WIDTH-1:0]              carryVec;
  logic [GROUP_COUNT:0]          groupCarry;

  cla_pg_stage #(.WIDTH(WIDTH)) pgStage (
    .opA   (opA),
    .opB   (opB),
    .terms (terms)
  );

  assign groupCarry[0] = carryIn;

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_grp
    cla_group #(.GROUP_W(GROUP_W)) grp (
      .terms    (terms[g*GROUP_W +: GROUP_W]),
      .groupCin (groupCarry[g]),
      .carryVec (carryVec[g*GROUP_W +: GROUP_W]),
      .sumBits  (sum[g*GROUP_W +: GROUP_W])
    );
    // Only the top carry of a group leaves it.
    assign groupCarry[g+1] = carryVec[g*GROUP_W + GROUP_W - 1];
  end

  assign carryOut = groupCarry[GROUP_COUNT];
  assign overflow = carryVec[WIDTH-1] ^ carryVec[WIDTH-2];

  // R1 and R2: port-level total against a plain addition.
  always_comb begin
    a_r2_total_matches: assert ({carryOut, sum} ==
        ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
      else $error("R1/R2 total mismatch");
  end

  // R3: overflow tied to operand and result signs.
  always_comb begin
    a_r3_overflow_signs: assert (overflow ==
        ((opA[WIDTH-1] == opB[WIDTH-1]) && (sum[WIDTH-1] != opA[WIDTH-1])))
      else $error("R3 overflow flag mismatch");
  end
endmodule

// File: tb/grouped_cla_adder_test.sv
module grouped_cla_adder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sum;
  logic        carryOut;
  logic        overflow;
  int          nTests = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  grouped_cla_adder uut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut), .overflow(overflow)
  );

  function automatic logic [16:0] refTotal(logic [15:0] a, logic [15:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  function automatic logic refOvf(logic [15:0] a, logic [15:0] b, logic c);
    logic [16:0] t;
    t = refTotal(a, b, c);
    return (a[15] == b[15]) && (t[15] != a[15]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, opA, opB, carryIn);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #2;
  endtask

  task automatic fullCheck(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] t;
    drive(a, b, c);
    t = refTotal(a, b, c);
    check("R1", {16'd0, sum}, {16'd0, t[15:0]});
    check("R2", {31'd0, carryOut}, {31'd0, t[16]});
    check("R3", {31'd0, overflow}, {31'd0, refOvf(a, b, c)});
  endtask

  initial begin
    logic [31:0] seedDummy;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // All-zero inputs give an all-zero result.
    drive(16'h0, 16'h0, 1'b0);
    check("R1 zero", {16'd0, sum}, 32'd0);
    check("R2 zero", {31'd0, carryOut}, 32'd0);
    check("R3 zero", {31'd0, overflow}, 32'd0);

    // R4: carry-in propagates across every group.
    drive(16'hFFFF, 16'h0000, 1'b1);
    check("R4 sum", {16'd0, sum}, 32'd0);
    check("R4 cout", {31'd0, carryOut}, 32'd1);
    drive(16'h0000, 16'hFFFF, 1'b0);
    check("R4 no-cin", {16'd0, sum}, 32'h0000FFFF);

    // R3 signed corners.
    fullCheck(16'h7FFF, 16'h0001, 1'b0);
    check("R3 pos ovf", {31'd0, overflow}, 32'd1);
    fullCheck(16'hFFFF, 16'h0001, 1'b0);
    check("R3 no ovf", {31'd0, overflow}, 32'd0);
    fullCheck(16'h8000, 16'h8000, 1'b0);
    check("R3 neg ovf", {31'd0, overflow}, 32'd1);
    fullCheck(16'h8000, 16'hFFFF, 1'b0);
    fullCheck(16'h7FFF, 16'h0000, 1'b1);
    check("R3 cin ovf", {31'd0, overflow}, 32'd1);

    // R5: single generate walks across every bit.
    for (int i = 0; i < 16; i++) begin
      drive(16'h1 << i, 16'h1 << i, 1'b0);
      if (i < 15) begin
        check("R5 sum", {16'd0, sum}, 32'h1 << (i + 1));
        check("R5 cout", {31'd0, carryOut}, 32'd0);
      end else begin
        check("R5 top sum", {16'd0, sum}, 32'd0);
        check("R5 top cout", {31'd0, carryOut}, 32'd1);
      end
    end

    // R6: exhaustive 4-bit slices in each group position.
    for (int g = 0; g < 4; g++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int c = 0; c < 2; c++) begin
            logic [16:0] t;
            logic [15:0] aw;
            logic [15:0] bw;
            aw = 16'(a) << (4 * g);
            bw = 16'(b) << (4 * g);
            drive(aw, bw, (g == 0) ? c[0] : 1'b0);
            t = refTotal(aw, bw, (g == 0) ? c[0] : 1'b0);
            check("R6", {15'd0, carryOut, sum}, {15'd0, t});
          end
        end
      end
    end

    // Random full-width vectors for R1, R2, R3.
    seedDummy = $urandom(32'h5EED1234);
    for (int n = 0; n < 3000; n++) begin
      fullCheck(16'($urandom), 16'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule